// File: doc/BRIEF.md
# I2C Slave Address Match Detector

This block watches the two wires of an I2C bus from a node that can act as a slave, and decides whether the current transfer is meant for that node. Both bus lines are resynchronized to the local clock. The block then finds START and STOP conditions and shifts in the bytes that follow a START. It keeps an addressed-as-slave status flag, which it sets or clears according to the configured addressing mode. It never drives the bus. Acknowledge generation, data movement and master operation belong to neighbouring logic that reads the flag.

Three addressing modes are available. In 7-bit mode the node compares the low seven bits of its own address. In 10-bit mode the full ten-bit own address is compared across two address bytes. In free data format no address is used, and any transfer claims the node. Each mode has its own rules for clearing the flag. A 3-bit bit-count setting gives the length of data bytes. A loopback-enable input marks configurations in which free data format cannot be used. The status flag is also available as an interrupt request gated by an enable, and a companion output reports that the flag was set by a general call.

Top module: `i2c_addr_match`

## Requirements
- R1: With `mode_sel`=2'b00 (7-bit; 2'b11 acts the same), a first byte after START whose bits [7:1] equal `own_addr[6:0]` sets `addressed`. `own_addr[9:7]` plays no part, and a non-matching first byte leaves the flag unchanged.
- R2: A first byte of 8'h00 (general call) sets both `addressed` and `general_call` in 7-bit and 10-bit modes. `general_call` is low whenever `addressed` is low, and it is low after a match on the own address.
- R3: With `mode_sel`=2'b01 (10-bit), a first byte of 5'b11110, `own_addr[9:8]` and R/W=0, followed by a second byte equal to `own_addr[7:0]`, sets `addressed`. The first byte alone does not set it. A first byte with 5'b11110, `own_addr[9:8]` and R/W=1 leaves the flag unchanged.
- R4: In 10-bit mode, a received address that differs from the own address clears `addressed`. This covers a first byte that is neither 8'h00 nor 5'b11110 with `own_addr[9:8]`, and a second byte that differs from `own_addr[7:0]`.
- R5: A repeated START (a START while a transfer is open) clears `addressed` in 7-bit mode only. In 10-bit mode and in free data format it leaves the flag unchanged.
- R6: In every mode a STOP clears `addressed`. So does an acknowledge slot that reads SDA high (NACK).
- R7: With `mode_sel`=2'b10 (free data format), the first byte after START sets `addressed` without any compare.
- R8: A data byte (any byte in free data format) holds `bit_count` bits, where 0 means 8, and is followed by one acknowledge slot. Address bytes always hold 8 bits.
- R9: `cfg_error` is high exactly when `loopback_en`=1 and `mode_sel`=2'b10. While it is high, free-data-format bytes do not set `addressed`.
- R10: `irq` equals `addressed` AND `irq_en`.
- R11: After reset, `addressed`, `general_call` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| mode_sel | input | 2 | 00 7-bit, 01 10-bit, 10 free data format, 11 as 7-bit |
| own_addr | input | 10 | Own slave address |
| loopback_en | input | 1 | Loopback enabled (forbids free data format) |
| bit_count | input | 3 | Bits per data byte, 0 means 8 |
| irq_en | input | 1 | Interrupt enable |
| addressed | output | 1 | Addressed-as-slave flag |
| irq | output | 1 | Masked interrupt request |
| general_call | output | 1 | Flag was set by a general call |
| cfg_error | output | 1 | Free data format requested with loopback |

## Verification
A change on a bus line reaches `addressed` and `general_call` on the third rising clock edge after the line moves. Two edges go to the synchronizer and one to the flag register. `irq` and `cfg_error` follow their inputs within the same cycle. The bench holds each bus level for six clock cycles, which is twice the longest latency. It queues an expected value only after the full hold has passed, and the monitor compares on a falling edge while the lines are quiet. So every comparison falls after the result is due and before the next bus event.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  typedef enum logic [1:0] {
    AM_7BIT  = 2'b00,
    AM_10BIT = 2'b01,
    AM_FREE  = 2'b10,
    AM_RSVD  = 2'b11
  } am_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_DATA
  } am_state_e;

  localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= {WIDTH{RST_VAL}};
        end else begin
          if (s == 0) chain_q[s] <= d_in;
          else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    start_ev = scl_s & scl_p & sda_p & ~sda_s;
    stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
    scl_rise = scl_s & ~scl_p;
  end

endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              scl_rise,
  input  logic              sda_s,
  input  logic [CNT_W-1:0]  len,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              ack_done,
  output logic              nack
);

  logic              active_q, active_d;
  logic              in_ack_q, in_ack_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic              take;

  always_comb begin
    take      = active_q & scl_rise & ~in_ack_q;
    byte_done = take & (cnt_q == (len - CNT_W'(1)));
    byte_val  = {shreg_q[BYTE_W-2:0], sda_s};
    ack_done  = active_q & scl_rise & in_ack_q;
    nack      = sda_s;

    active_d = active_q;
    in_ack_d = in_ack_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;

    if (start_ev) begin
      active_d = 1'b1;
      in_ack_d = 1'b0;
      cnt_d    = '0;
    end else if (stop_ev) begin
      active_d = 1'b0;
      in_ack_d = 1'b0;
      cnt_d    = '0;
    end else if (ack_done) begin
      in_ack_d = 1'b0;
      cnt_d    = '0;
    end else if (take) begin
      shreg_d = byte_val;
      if (byte_done) begin
        in_ack_d = 1'b1;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      in_ack_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
    end else begin
      active_q <= active_d;
      in_ack_q <= in_ack_d;
      cnt_q    <= cnt_d;
      if (take) shreg_q <= shreg_d;
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len);

endmodule

// File: rtl/i2c_am_match.sv
module i2c_am_match
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter int BC_W   = 3,
  parameter int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              ack_done,
  input  logic              nack,
  input  logic [1:0]        mode_sel,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              loopback_en,
  input  logic [BC_W-1:0]   bit_count,
  output logic [CNT_W-1:0]  len,
  output logic              addressed,
  output logic              general_call,
  output logic              cfg_error
);

  localparam int SHORT_W = BYTE_W - 1;

  am_state_e state_q, state_d;
  logic      addr_q, addr_d;
  logic      gc_q, gc_d;
  logic      mode_7b, mode_10b, mode_free;
  logic      busy, is_gc, short_hit, prefix_hit, low_hit;

  always_comb begin
    mode_10b   = (am_mode_e'(mode_sel) == AM_10BIT);
    mode_free  = (am_mode_e'(mode_sel) == AM_FREE);
    mode_7b    = ~mode_10b & ~mode_free;
    cfg_error  = mode_free & loopback_en;
    busy       = (state_q != ST_IDLE);
    is_gc      = (byte_val == '0);
    short_hit  = (byte_val[BYTE_W-1:1] == own_addr[SHORT_W-1:0]);
    prefix_hit = (byte_val[7:3] == TEN_BIT_PREFIX) &&
                 (byte_val[2:1] == own_addr[ADDR_W-1:ADDR_W-2]);
    low_hit    = (byte_val == own_addr[BYTE_W-1:0]);
    if (mode_free && (state_q == ST_FIRST || state_q == ST_DATA))
      len = (bit_count == '0) ? CNT_W'(BYTE_W) : CNT_W'(bit_count);
    else if (!mode_free && state_q == ST_DATA)
      len = (bit_count == '0) ? CNT_W'(BYTE_W) : CNT_W'(bit_count);
    else
      len = CNT_W'(BYTE_W);
  end

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    gc_d    = gc_q;

    if (stop_ev) begin
      state_d = ST_IDLE;
      addr_d  = 1'b0;
    end else if (start_ev) begin
      state_d = ST_FIRST;
      if (busy && mode_7b) addr_d = 1'b0;
    end else if (ack_done && nack) begin
      addr_d = 1'b0;
    end else if (byte_done) begin
      unique case (state_q)
        ST_FIRST: begin
          state_d = ST_DATA;
          if (mode_free) begin
            if (!cfg_error) begin
              addr_d = 1'b1;
              gc_d   = 1'b0;
            end
          end else if (is_gc) begin
            addr_d = 1'b1;
            gc_d   = 1'b1;
          end else if (mode_10b) begin
            if (prefix_hit) begin
              if (!byte_val[0]) state_d = ST_SECOND;
            end else begin
              addr_d = 1'b0;
            end
          end else if (short_hit) begin
            addr_d = 1'b1;
            gc_d   = 1'b0;
          end
        end
        ST_SECOND: begin
          state_d = ST_DATA;
          if (low_hit) begin
            addr_d = 1'b1;
            gc_d   = 1'b0;
          end else begin
            addr_d = 1'b0;
          end
        end
        default: ;
      endcase
    end

    if (!addr_d) gc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= 1'b0;
      gc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      gc_q    <= gc_d;
    end
  end

  assign addressed    = addr_q;
  assign general_call = gc_q;

  p_stop_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !addressed);

  p_nack_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && nack) |=> !addressed);

  p_gc_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    general_call |-> addressed);

  p_rstart_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && busy && mode_7b) |=> !addressed);

  p_lb_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cfg_error && !addressed && !start_ev && !stop_ev) |=> !addressed);

  p_second_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state_q == ST_SECOND && low_hit && !start_ev && !stop_ev)
      |=> addressed);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter int BC_W   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        mode_sel,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              loopback_en,
  input  logic [BC_W-1:0]   bit_count,
  input  logic              irq_en,
  output logic              addressed,
  output logic              irq,
  output logic              general_call,
  output logic              cfg_error
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic              rst_meta_q, rst_sync_q;
  logic [1:0]        lines_s;
  logic              start_ev, stop_ev, scl_rise;
  logic              byte_done, ack_done, nack;
  logic [BYTE_W-1:0] byte_val;
  logic [CNT_W-1:0]  len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  i2c_am_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_in  ({scl_i, sda_i}),
    .d_out (lines_s)
  );

  i2c_am_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .scl_s    (lines_s[1]),
    .sda_s    (lines_s[0]),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise)
  );

  i2c_am_shift #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .scl_rise  (scl_rise),
    .sda_s     (lines_s[0]),
    .len       (len),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .ack_done  (ack_done),
    .nack      (nack)
  );

  i2c_am_match #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BC_W(BC_W), .CNT_W(CNT_W)) u_match (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .start_ev     (start_ev),
    .stop_ev      (stop_ev),
    .byte_done    (byte_done),
    .byte_val     (byte_val),
    .ack_done     (ack_done),
    .nack         (nack),
    .mode_sel     (mode_sel),
    .own_addr     (own_addr),
    .loopback_en  (loopback_en),
    .bit_count    (bit_count),
    .len          (len),
    .addressed    (addressed),
    .general_call (general_call),
    .cfg_error    (cfg_error)
  );

  assign irq = addressed & irq_en;

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en) |-> !irq);

endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl, sda;
  logic [1:0] mode_sel;
  logic [9:0] own_addr;
  logic       loopback_en, irq_en;
  logic [2:0] bit_count;
  logic       addressed, irq, general_call, cfg_error;

  int n_checks = 0;
  int n_bad    = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    logic  a, g, i, e;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  always #4 clk = ~clk;

  i2c_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .mode_sel(mode_sel), .own_addr(own_addr), .loopback_en(loopback_en),
    .bit_count(bit_count), .irq_en(irq_en), .addressed(addressed),
    .irq(irq), .general_call(general_call), .cfg_error(cfg_error)
  );

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      n_checks++;
      if ({addressed, general_call, irq, cfg_error} !== {cur.a, cur.g, cur.i, cur.e}) begin
        n_bad++;
        $display("FAIL %s: got addr/gc/irq/cerr=%b%b%b%b expected %b%b%b%b",
                 cur.tag, addressed, general_call, irq, cfg_error,
                 cur.a, cur.g, cur.i, cur.e);
      end
    end
  end

  task automatic expect_st(string tag, logic a, logic g, logic i, logic e);
    exp_t it;
    @(posedge clk);
    it.tag = tag; it.a = a; it.g = g; it.i = i; it.e = e;
    exp_q.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic gap();
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; scl = 1'b1; gap(); sda = 1'b0; gap(); scl = 1'b0; gap();
  endtask

  task automatic bus_rstart();
    sda = 1'b1; gap(); scl = 1'b1; gap(); sda = 1'b0; gap(); scl = 1'b0; gap();
  endtask

  task automatic bus_stop();
    sda = 1'b0; gap(); scl = 1'b1; gap(); sda = 1'b1; gap();
  endtask

  task automatic bus_bit(logic b);
    sda = b; gap(); scl = 1'b1; gap(); scl = 1'b0; gap();
  endtask

  task automatic bus_bits(logic [7:0] v, int n);
    for (int k = n - 1; k >= 0; k--) bus_bit(v[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
    mode_sel = 2'b00; own_addr = 10'h2A5; loopback_en = 1'b0;
    bit_count = 3'd0; irq_en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    expect_st("R11 reset", 0, 0, 0, 0);

    // R1: 7-bit match on own_addr[6:0]=0x25, upper bits 3'b101 ignored
    bus_start(); bus_bits(8'h4A, 8);
    expect_st("R1 7-bit match", 1, 0, 1, 0);
    bus_bit(1'b0); bus_bits(8'h5C, 8); bus_bit(1'b0);
    expect_st("R1 held over data", 1, 0, 1, 0);
    bus_stop();
    expect_st("R6 stop clears", 0, 0, 0, 0);

    bus_start(); bus_bits(8'h4C, 8);
    expect_st("R1 7-bit mismatch", 0, 0, 0, 0);
    bus_bit(1'b1); bus_stop();

    // R2 general call, then R5 repeated start clears in 7-bit
    bus_start(); bus_bits(8'h00, 8);
    expect_st("R2 general call", 1, 1, 1, 0);
    bus_bit(1'b0); bus_rstart();
    expect_st("R5 rstart clears 7-bit", 0, 0, 0, 0);
    bus_bits(8'h4A, 8);
    expect_st("R2 own match drops gc", 1, 0, 1, 0);
    bus_bit(1'b1);
    expect_st("R6 nack clears", 0, 0, 0, 0);
    bus_stop();

    // R10 interrupt gating
    irq_en = 1'b0;
    bus_start(); bus_bits(8'h4A, 8);
    expect_st("R10 irq masked", 1, 0, 0, 0);
    irq_en = 1'b1;
    expect_st("R10 irq enabled", 1, 0, 1, 0);
    bus_bit(1'b0); bus_stop();

    // R8: address byte stays 8 bits even with bit_count=3
    bit_count = 3'd3;
    bus_start(); bus_bits(8'h4A, 8);
    expect_st("R8 address byte 8 bits", 1, 0, 1, 0);
    bus_bit(1'b0); bus_bits(8'h05, 3); bus_bit(1'b1);
    expect_st("R8 3-bit data then nack slot", 0, 0, 0, 0);
    bus_stop();
    bit_count = 3'd0;

    // 10-bit mode, own 0x2A5: first byte 0xF4, second 0xA5
    mode_sel = 2'b01;
    bus_start(); bus_bits(8'hF4, 8);
    expect_st("R3 first byte alone", 0, 0, 0, 0);
    bus_bit(1'b0); bus_bits(8'hA5, 8);
    expect_st("R3 10-bit match", 1, 0, 1, 0);
    bus_bit(1'b0); bus_rstart();
    expect_st("R5 rstart keeps 10-bit", 1, 0, 1, 0);
    bus_bits(8'hF5, 8);
    expect_st("R3 read header keeps", 1, 0, 1, 0);
    bus_bit(1'b0); bus_stop();
    expect_st("R6 stop clears 10-bit", 0, 0, 0, 0);

    bus_start(); bus_bits(8'hF4, 8); bus_bit(1'b0); bus_bits(8'hA5, 8); bus_bit(1'b0);
    bus_rstart(); bus_bits(8'hF4, 8); bus_bit(1'b0); bus_bits(8'hA6, 8);
    expect_st("R4 second byte mismatch", 0, 0, 0, 0);
    bus_bit(1'b1); bus_stop();

    bus_start(); bus_bits(8'hF4, 8); bus_bit(1'b0); bus_bits(8'hA5, 8); bus_bit(1'b0);
    bus_rstart(); bus_bits(8'hF0, 8);
    expect_st("R4 header mismatch", 0, 0, 0, 0);
    bus_bit(1'b1); bus_stop();

    bus_start(); bus_bits(8'hF2, 8); bus_bit(1'b0); bus_bits(8'hA5, 8);
    expect_st("R3 upper bits compared", 0, 0, 0, 0);
    bus_bit(1'b1); bus_stop();

    bus_start(); bus_bits(8'h00, 8);
    expect_st("R2 general call 10-bit", 1, 1, 1, 0);
    bus_bit(1'b0); bus_stop();

    // free data format
    mode_sel = 2'b10;
    bus_start(); bus_bits(8'h13, 8);
    expect_st("R7 free byte sets", 1, 0, 1, 0);
    bus_bit(1'b0); bus_rstart();
    expect_st("R5 rstart keeps free", 1, 0, 1, 0);
    bus_stop();
    expect_st("R6 stop clears free", 0, 0, 0, 0);

    bit_count = 3'd3;
    bus_start(); bus_bits(8'h05, 3);
    expect_st("R8 free 3-bit byte", 1, 0, 1, 0);
    bus_bit(1'b1);
    expect_st("R8 ack slot after 3 bits", 0, 0, 0, 0);
    bus_stop();
    bit_count = 3'd0;

    loopback_en = 1'b1;
    expect_st("R9 cfg error", 0, 0, 0, 1);
    bus_start(); bus_bits(8'h13, 8);
    expect_st("R9 free blocked", 0, 0, 0, 1);
    bus_bit(1'b1); bus_stop();
    mode_sel = 2'b00;
    expect_st("R9 loopback 7-bit ok", 0, 0, 0, 0);

    repeat (10) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule